// File: doc/BRIEF.md
# Indirect Multiply-Divide Unit

An unsigned arithmetic unit that a host reaches through a single byte-wide port with three selectable targets: a command/status byte, a pointer into an internal byte array, and a data window onto that array. The array holds two 16-bit multiplier operands, a 32-bit product, a 32-bit dividend, a 16-bit divisor and a 32-bit quotient. Every access through the data window moves the pointer on by one, so a multi-byte value is streamed with its most significant byte first.

Writing an operation code to the command byte starts work. A multiply finishes at the next clock edge. A divide runs as a restoring shift-subtract loop that produces one quotient bit per clock over 32 clocks. At the end the remainder replaces the dividend in the array and the quotient is written to its own field. A divisor of zero is caught at once: a status flag is raised, the quotient becomes all ones and the dividend is kept.

Top module: `mdc_calc`

## Requirements
- R1: After reset the pointer is 0, every array byte reads 0x00, and the status byte reads 0x01: bit 0 is done/idle and bit 1 is the zero-divisor flag.
- R2: Writing to the pointer target (sel_i = 1) loads the pointer from wdata_i[4:0]. Every read or write through the data window (sel_i = 2) then advances the pointer by one, wrapping from 31 to 0. The pointer target reads back the pointer value.
- R3: Array layout, most significant byte at the lowest address: multiplier A at 0-1, multiplier B at 2-3, product at 4-7, dividend at 8-11, divisor at 12-13, quotient at 14-17. Addresses 18-31 read 0x00 and ignore writes.
- R4: Writing code 0x01 to the command target (sel_i = 0) loads A*B into the product field at the next clock edge. Done stays 1 throughout.
- R5: Writing code 0x02 with a non-zero divisor clears done for exactly 32 clocks following the write, and done then returns to 1.
- R6: When a divide completes, the quotient field holds floor(dividend/divisor), the dividend field holds the remainder zero-extended to 32 bits, and the divisor is unchanged.
- R7: A divide with a zero divisor sets the zero flag, writes 0xFFFFFFFF to the quotient, leaves the dividend unchanged and never clears done. The next divide with a non-zero divisor clears the flag.
- R8: While a divide runs, writes through the data window change no byte but still advance the pointer, and command writes are ignored.
- R9: The product and quotient fields cannot be written through the data window.
- R10: Command codes 0x00 and 0x03 start nothing and change no byte or status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Target: 0 command/status, 1 pointer, 2 data window |
| wr_en_i | input | 1 | Write strobe for the selected target |
| rd_en_i | input | 1 | Read strobe; advances the pointer when the data window is selected |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected target at the current pointer (combinational) |

## Verification
A wrong pointer shows up on the very next data-window access, because every byte the window returns then comes from the wrong field. A wrong count in the divide sequencer shows up in the status byte, which is polled every clock: done then drops for more or fewer than 32 cycles. A bad shift-subtract step survives to the end of the divide and appears as a wrong quotient or remainder byte 32 clocks after the start. Operand corruption during a divide is caught when the operand bytes are read back after completion.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  localparam logic [1:0] PORT_CTRL = 2'd0;
  localparam logic [1:0] PORT_IDX  = 2'd1;
  localparam logic [1:0] PORT_DATA = 2'd2;

  localparam logic [1:0] OP_MUL = 2'b01;
  localparam logic [1:0] OP_DIV = 2'b10;

  localparam int ST_DONE = 0;
  localparam int ST_DZ   = 1;
endpackage

// File: rtl/mdc_index.sv
module mdc_index #(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_val_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (set_i)  idx_q <= set_val_i;
    else if (step_i) idx_q <= idx_q + IDX_W'(1);
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/mdc_opreg.sv
module mdc_opreg #(
  parameter int W     = 16,
  parameter int BASE  = 0,
  parameter int IDX_W = 5,
  parameter bit SW_WR = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  input  logic             ld_i,
  input  logic [W-1:0]     ld_val_i,
  output logic [W-1:0]     q_o
);
  localparam int NB = W / 8;
  localparam logic [IDX_W-1:0] LO = IDX_W'(BASE);

  logic [W-1:0]     q_q, d;
  logic [IDX_W-1:0] off;
  logic             hit;

  assign off = idx_i - LO;
  assign hit = SW_WR && wr_i && (off < IDX_W'(NB));

  // hardware load wins over a host byte write
  always_comb begin
    d = q_q;
    if (ld_i) begin
      d = ld_val_i;
    end else if (hit) begin
      for (int b = 0; b < NB; b++) begin
        if (off == IDX_W'(NB - 1 - b)) d[b*8 +: 8] = wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/mdc_div.sv
module mdc_div #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [DVD_W-1:0] dvd_i,
  input  logic [DVS_W-1:0] dvs_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [DVD_W-1:0] quot_o,
  output logic [DVS_W-1:0] rem_o
);
  localparam int CNT_W = $clog2(DVD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DVS_W-1:0] rem_q, dvs_q, rem_nx, diff_lo;
  logic [DVD_W-1:0] q_q, q_nx;
  logic [DVS_W:0]   trial;
  logic             borrow, ge;

  // restoring step: shift one dividend bit in, subtract when it fits
  assign trial            = {rem_q, q_q[DVD_W-1]};
  assign {borrow, diff_lo} = {1'b0, trial[DVS_W-1:0]} - {1'b0, dvs_q};
  assign ge               = trial[DVS_W] | ~borrow;
  assign rem_nx           = ge ? diff_lo : trial[DVS_W-1:0];
  assign q_nx             = {q_q[DVD_W-2:0], ge};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      q_q    <= '0;
      dvs_q  <= '0;
    end else if (busy_q) begin
      rem_q <= rem_nx;
      q_q   <= q_nx;
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == LAST) busy_q <= 1'b0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      rem_q  <= '0;
      q_q    <= dvd_i;
      dvs_q  <= dvs_i;
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (cnt_q == LAST);
  assign quot_o = q_nx;
  assign rem_o  = rem_nx;
endmodule

// File: rtl/mdc_calc.sv
module mdc_calc #(
  parameter int MUL_W = 16,
  parameter int DVD_W = 32,
  parameter int DVS_W = 16,
  parameter int IDX_W = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  import mdc_pkg::*;

  localparam int PROD_W = 2 * MUL_W;
  localparam int A_MA   = 0;
  localparam int A_MB   = A_MA + MUL_W / 8;
  localparam int A_MO   = A_MB + MUL_W / 8;
  localparam int A_DA   = A_MO + PROD_W / 8;
  localparam int A_DB   = A_DA + DVD_W / 8;
  localparam int A_DQ   = A_DB + DVS_W / 8;
  localparam int A_END  = A_DQ + DVD_W / 8;
  localparam int IMG_W  = A_END * 8;

  logic [IDX_W-1:0] idx_q;
  logic [MUL_W-1:0] ma_q, mb_q;
  logic [PROD_W-1:0] mo_q, prod;
  logic [DVD_W-1:0] da_q, dq_q, div_quot, dq_val;
  logic [DVS_W-1:0] db_q, div_rem;
  logic             div_busy, div_fin, dz_q;
  logic             ctrl_wr, mul_go, div_req, div_go, zero_go;
  logic             data_acc, data_wr;
  logic [IMG_W-1:0] img;
  logic [7:0]       data_byte, st_byte;

  assign ctrl_wr  = wr_en_i && (sel_i == PORT_CTRL) && !div_busy;
  assign mul_go   = ctrl_wr && (wdata_i[1:0] == OP_MUL);
  assign div_req  = ctrl_wr && (wdata_i[1:0] == OP_DIV);
  assign div_go   = div_req && (db_q != '0);
  assign zero_go  = div_req && (db_q == '0);
  assign data_acc = (wr_en_i || rd_en_i) && (sel_i == PORT_DATA);
  assign data_wr  = wr_en_i && (sel_i == PORT_DATA) && !div_busy;

  mdc_index #(.IDX_W(IDX_W)) u_index (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (wr_en_i && (sel_i == PORT_IDX)),
    .set_val_i(wdata_i[IDX_W-1:0]),
    .step_i   (data_acc),
    .idx_o    (idx_q)
  );

  assign prod = PROD_W'(ma_q) * PROD_W'(mb_q);

  mdc_opreg #(.W(MUL_W), .BASE(A_MA), .IDX_W(IDX_W), .SW_WR(1'b1)) u_ma (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(data_wr), .idx_i(idx_q), .wdata_i(wdata_i),
    .ld_i(1'b0), .ld_val_i('0), .q_o(ma_q)
  );

  mdc_opreg #(.W(MUL_W), .BASE(A_MB), .IDX_W(IDX_W), .SW_WR(1'b1)) u_mb (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(data_wr), .idx_i(idx_q), .wdata_i(wdata_i),
    .ld_i(1'b0), .ld_val_i('0), .q_o(mb_q)
  );

  mdc_opreg #(.W(PROD_W), .BASE(A_MO), .IDX_W(IDX_W), .SW_WR(1'b0)) u_mo (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(data_wr), .idx_i(idx_q), .wdata_i(wdata_i),
    .ld_i(mul_go), .ld_val_i(prod), .q_o(mo_q)
  );

  mdc_opreg #(.W(DVD_W), .BASE(A_DA), .IDX_W(IDX_W), .SW_WR(1'b1)) u_da (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(data_wr), .idx_i(idx_q), .wdata_i(wdata_i),
    .ld_i(div_fin), .ld_val_i(DVD_W'(div_rem)), .q_o(da_q)
  );

  mdc_opreg #(.W(DVS_W), .BASE(A_DB), .IDX_W(IDX_W), .SW_WR(1'b1)) u_db (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(data_wr), .idx_i(idx_q), .wdata_i(wdata_i),
    .ld_i(1'b0), .ld_val_i('0), .q_o(db_q)
  );

  assign dq_val = zero_go ? '1 : div_quot;

  mdc_opreg #(.W(DVD_W), .BASE(A_DQ), .IDX_W(IDX_W), .SW_WR(1'b0)) u_dq (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(data_wr), .idx_i(idx_q), .wdata_i(wdata_i),
    .ld_i(div_fin || zero_go), .ld_val_i(dq_val), .q_o(dq_q)
  );

  mdc_div #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (div_go),
    .dvd_i (da_q),
    .dvs_i (db_q),
    .busy_o(div_busy),
    .fin_o (div_fin),
    .quot_o(div_quot),
    .rem_o (div_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dz_q <= 1'b0;
    else if (div_req) dz_q <= zero_go;
  end

  assign img = {ma_q, mb_q, mo_q, da_q, db_q, dq_q};

  always_comb begin
    data_byte = '0;
    for (int a = 0; a < A_END; a++) begin
      if (idx_q == IDX_W'(a)) data_byte = img[(A_END-1-a)*8 +: 8];
    end
  end

  always_comb begin
    st_byte          = '0;
    st_byte[ST_DONE] = !div_busy;
    st_byte[ST_DZ]   = dz_q;
  end

  always_comb begin
    case (sel_i)
      PORT_CTRL: rdata_o = st_byte;
      PORT_IDX:  rdata_o = 8'(idx_q);
      PORT_DATA: rdata_o = data_byte;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mdc_calc_chk.sv
module mdc_calc_chk #(
  parameter int MUL_W = 16,
  parameter int DVD_W = 32,
  parameter int DVS_W = 16,
  parameter int IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       sel_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [1:0]       op_i,
  input logic [IDX_W-1:0] idx_i,
  input logic             busy_i,
  input logic             dz_i,
  input logic [DVS_W-1:0] db_i,
  input logic [MUL_W-1:0] ma_i,
  input logic [MUL_W-1:0] mb_i
);
  import mdc_pkg::*;

  localparam int RUN_W = $clog2(DVD_W) + 2;

  logic [RUN_W-1:0] run_q;
  logic             cmd_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_i) run_q <= run_q + RUN_W'(1);
    else             run_q <= '0;
  end

  assign cmd_idle = wr_en_i && (sel_i == PORT_CTRL) && !busy_i;

  a_r2_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en_i || rd_en_i) && (sel_i == PORT_DATA)) |=> (idx_i == $past(idx_i) + IDX_W'(1)));

  a_r4_mul_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_idle && (op_i == OP_MUL)) |=> !busy_i);

  a_r5_div_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_idle && (op_i == OP_DIV) && (db_i != '0)) |=> (busy_i && !dz_i));

  a_r5_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (run_q < RUN_W'(DVD_W)));

  a_r5_busy_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (run_q == RUN_W'(DVD_W)));

  a_r7_zero_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_idle && (op_i == OP_DIV) && (db_i == '0)) |=> (!busy_i && dz_i));

  a_r8_operands_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(ma_i) && $stable(mb_i) && $stable(db_i)));
endmodule

bind mdc_calc mdc_calc_chk #(
  .MUL_W(MUL_W), .DVD_W(DVD_W), .DVS_W(DVS_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .op_i   (wdata_i[1:0]),
  .idx_i  (idx_q),
  .busy_i (div_busy),
  .dz_i   (dz_q),
  .db_i   (db_q),
  .ma_i   (ma_q),
  .mb_i   (mb_q)
);

// File: tb/tb_mdc_calc.sv
`timescale 1ns/1ps
module tb_mdc_calc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  byte unsigned m[32];
  int           idx_m = 0;
  int           busy_m = 0;
  bit           dz_m = 1'b0;
  longint       pend_q = 0;
  longint       pend_r = 0;

  always #2.5 clk = ~clk;

  mdc_calc dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .sel_i  (sel),
    .wr_en_i(wr),
    .rd_en_i(rd),
    .wdata_i(wd),
    .rdata_o(rdata)
  );

  function automatic longint get_be(int base, int n);
    longint v = 0;
    for (int i = 0; i < n; i++) v = (v << 8) | longint'(m[base + i]);
    return v;
  endfunction

  function automatic void put_be(int base, int n, longint v);
    for (int i = n - 1; i >= 0; i--) begin
      m[base + i] = 8'(v & 255);
      v = v >> 8;
    end
  endfunction

  function automatic logic [7:0] exp_read(logic [1:0] s);
    case (s)
      2'd0: return {6'd0, dz_m, (busy_m == 0)};
      2'd1: return 8'(idx_m);
      2'd2: return m[idx_m];
      default: return 8'd0;
    endcase
  endfunction

  function automatic void model(logic [1:0] s, logic w, logic r, logic [7:0] d);
    bit     was_busy = (busy_m > 0);
    longint dvd, dvs;
    if (was_busy) begin
      busy_m--;
      if (busy_m == 0) begin
        put_be(8, 4, pend_r);
        put_be(14, 4, pend_q);
      end
    end
    if (w && s == 2'd0 && !was_busy) begin
      if (d[1:0] == 2'b01) put_be(4, 4, get_be(0, 2) * get_be(2, 2));
      if (d[1:0] == 2'b10) begin
        dvd = get_be(8, 4);
        dvs = get_be(12, 2);
        if (dvs == 0) begin
          dz_m = 1'b1;
          put_be(14, 4, 64'hFFFF_FFFF);
        end else begin
          dz_m   = 1'b0;
          busy_m = 32;
          pend_q = dvd / dvs;
          pend_r = dvd % dvs;
        end
      end
    end
    if (w && s == 2'd1) idx_m = int'(d) % 32;
    if (s == 2'd2 && (w || r)) begin
      if (w && !was_busy && (idx_m < 4 || (idx_m >= 8 && idx_m < 14))) m[idx_m] = d;
      idx_m = (idx_m + 1) % 32;
    end
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h (sel %0d idx %0d)", tag, act, exp, sel, idx_m);
    end
  endtask

  task automatic cyc(logic [1:0] s, logic w, logic r, logic [7:0] d, string tag);
    @(negedge clk);
    sel = s; wr = w; rd = r; wd = d;
    #1;
    check(tag, rdata, exp_read(s));
    @(posedge clk);
    #1;
    model(s, w, r, d);
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic set_idx(int a, string tag);
    cyc(2'd1, 1'b1, 1'b0, 8'(a), tag);
  endtask

  task automatic wr_word(int base, int n, longint v, string tag);
    set_idx(base, tag);
    for (int i = n - 1; i >= 0; i--) cyc(2'd2, 1'b1, 1'b0, 8'((v >> (8 * i)) & 255), tag);
  endtask

  task automatic rd_span(int base, int n, string tag);
    set_idx(base, tag);
    for (int i = 0; i < n; i++) cyc(2'd2, 1'b0, 1'b1, 8'd0, tag);
  endtask

  task automatic poll(int n, string tag);
    for (int i = 0; i < n; i++) cyc(2'd0, 1'b0, 1'b0, 8'd0, tag);
  endtask

  task automatic run_div(longint dvd, longint dvs, string tag);
    wr_word(8, 4, dvd, tag);
    wr_word(12, 2, dvs, tag);
    cyc(2'd0, 1'b1, 1'b0, 8'h02, "R5");
    poll(34, "R5");
    rd_span(8, 10, tag);
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL R5 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    poll(1, "R1");
    cyc(2'd1, 1'b0, 1'b0, 8'd0, "R1");
    rd_span(0, 18, "R1");

    // R3 R4 multiply
    wr_word(0, 2, 16'h1234, "R3");
    wr_word(2, 2, 16'hABCD, "R3");
    cyc(2'd0, 1'b1, 1'b0, 8'h01, "R4");
    poll(1, "R4");
    rd_span(0, 8, "R4");
    wr_word(0, 4, 32'hFFFF_FFFF, "R4");
    cyc(2'd0, 1'b1, 1'b0, 8'h01, "R4");
    rd_span(4, 4, "R4");

    // R5 R6 divide
    run_div(32'h89AB_CDEF, 16'h0123, "R6");
    run_div(32'h0000_0005, 16'h0007, "R6");
    run_div(32'hFFFF_FFFF, 16'hFFFF, "R6");
    run_div(32'h1234_5678, 16'h0001, "R6");

    // R8 accesses during a running divide
    wr_word(8, 4, 32'hDEAD_BEEF, "R8");
    wr_word(12, 2, 16'h00FD, "R8");
    cyc(2'd0, 1'b1, 1'b0, 8'h02, "R8");
    set_idx(0, "R8");
    cyc(2'd2, 1'b1, 1'b0, 8'h55, "R8");
    cyc(2'd1, 1'b0, 1'b0, 8'd0, "R8");
    cyc(2'd0, 1'b1, 1'b0, 8'h01, "R8");
    set_idx(8, "R8");
    cyc(2'd2, 1'b1, 1'b0, 8'h00, "R8");
    cyc(2'd2, 1'b1, 1'b0, 8'h00, "R8");
    set_idx(12, "R8");
    cyc(2'd2, 1'b1, 1'b0, 8'h01, "R8");
    poll(34, "R5");
    rd_span(0, 18, "R8");

    // R7 zero divisor, then cleared by a valid divide
    wr_word(8, 4, 32'hCAFE_BABE, "R7");
    wr_word(12, 2, 16'h0000, "R7");
    cyc(2'd0, 1'b1, 1'b0, 8'h02, "R7");
    poll(3, "R7");
    rd_span(8, 10, "R7");
    run_div(32'h0001_0000, 16'h0003, "R7");
    poll(1, "R7");

    // R9 result fields read-only
    set_idx(4, "R9");
    for (int i = 0; i < 4; i++) cyc(2'd2, 1'b1, 1'b0, 8'hA5, "R9");
    set_idx(14, "R9");
    for (int i = 0; i < 4; i++) cyc(2'd2, 1'b1, 1'b0, 8'h5A, "R9");
    rd_span(4, 4, "R9");
    rd_span(14, 4, "R9");

    // R3 unused addresses
    set_idx(20, "R3");
    cyc(2'd2, 1'b1, 1'b0, 8'hAA, "R3");
    rd_span(18, 14, "R3");

    // R2 pointer wrap
    set_idx(31, "R2");
    cyc(2'd1, 1'b0, 1'b0, 8'd0, "R2");
    cyc(2'd2, 1'b0, 1'b1, 8'd0, "R2");
    cyc(2'd2, 1'b0, 1'b1, 8'd0, "R2");
    cyc(2'd1, 1'b0, 1'b0, 8'd0, "R2");

    // R10 inert command codes
    wr_word(0, 4, 32'h0102_0304, "R10");
    cyc(2'd0, 1'b1, 1'b0, 8'h00, "R10");
    cyc(2'd0, 1'b1, 1'b0, 8'h03, "R10");
    poll(2, "R10");
    rd_span(0, 18, "R10");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule